// File: doc/BRIEF.md
# Alternating-Polarity Ripple-Carry Adder

This block adds two unsigned WIDTH-bit operands and a carry-in, producing a WIDTH-bit sum and a carry-out. It is purely combinational. The carry chain is a row of full-adder cells in which every carry stage ends in a minority gate, so no stage carries an output inverter on the carry path.

It relies on the fact that a full adder with all three inputs complemented yields both outputs complemented. Cells at even bit positions take true operands and a true carry, and pass on an inverted carry. Cells at odd positions take inverted operands and that inverted carry, and pass on a true carry. Each cell forms its sum from its own inverted carry output. The odd-position sum comes out complemented and is turned back to true polarity off the carry path. When WIDTH is odd the last carry leaving the chain is inverted, so it is corrected once at the output.

Top module: `apr_adder`

## Requirements
- R1: For every pair of operands and every carry-in, the concatenation {cout_o, sum_o} equals a_i + b_i + cin_i, computed as an unsigned WIDTH+1-bit value.
- R2: With a_i all ones, b_i zero and cin_i = 1, the carry travels the whole chain: sum_o is zero and cout_o is 1.
- R3: With b_i zero and cin_i = 0, sum_o equals a_i and cout_o is 0.
- R4: With b_i equal to the bitwise complement of a_i, sum_o is all ones and cout_o is 0 when cin_i = 0, and sum_o is zero and cout_o is 1 when cin_i = 1.
- R5: When bit WIDTH-1 of both operands is 1, cout_o is 1. When bit WIDTH-1 of both operands is 0, cout_o is 0.
- R6: cout_o and every bit of sum_o are true polarity for both odd and even WIDTH. R1 holds exhaustively at WIDTH = 5 and at WIDTH = 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, unsigned |
| b_i | input | WIDTH | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits, true polarity |
| cout_o | output | 1 | Carry out of bit WIDTH-1, true polarity |

## Verification
The checks assume that every input is a settled two-state value. Each check is skipped while any input bit is unknown, and it runs once the inputs settle. The bench drives only defined values, changing them on one clock edge and reading the outputs on the opposite edge, so every observation follows settled inputs. One odd-width and one even-width instance are swept over every input combination, and the wide default instance gets corner operands and random ones.

// File: rtl/apr_pkg.sv
package apr_pkg;

    typedef struct packed {
        logic sum;
        logic carry;
    } fa_res_t;

    function automatic logic minority3(input logic x, input logic y, input logic z);
        return ~((x & y) | (x & z) | (y & z));
    endfunction

    function automatic logic sum_from_ncarry(input logic x, input logic y,
                                             input logic z, input logic ncarry);
        return (x & y & z) | ((x | y | z) & ncarry);
    endfunction

    function automatic bit is_odd_pos(input int idx);
        return (idx % 2) == 1;
    endfunction

endpackage

// File: rtl/apr_cell_even.sv
module apr_cell_even
    import apr_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    ci,
    output fa_res_t res
);
    logic ncarry;

    always_comb begin
        ncarry    = minority3(a, b, ci);
        res.carry = ncarry;
        res.sum   = sum_from_ncarry(a, b, ci, ncarry);
    end
endmodule

// File: rtl/apr_cell_odd.sv
module apr_cell_odd
    import apr_pkg::*;
(
    input  logic    a_n,
    input  logic    b_n,
    input  logic    ci_n,
    output fa_res_t res
);
    logic carry_true;

    always_comb begin
        carry_true = minority3(a_n, b_n, ci_n);
        res.carry  = carry_true;
        res.sum    = sum_from_ncarry(a_n, b_n, ci_n, carry_true);
    end
endmodule

// File: rtl/apr_ripple_chain.sv
module apr_ripple_chain
    import apr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_last
);
    logic [WIDTH:0] link;
    fa_res_t        res [WIDTH];

    assign link[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (is_odd_pos(i)) begin : g_odd
            logic a_n, b_n;
            assign a_n = ~a[i];
            assign b_n = ~b[i];
            apr_cell_odd u_cell (
                .a_n  (a_n),
                .b_n  (b_n),
                .ci_n (link[i]),
                .res  (res[i])
            );
            assign sum[i] = ~res[i].sum;
        end else begin : g_even
            apr_cell_even u_cell (
                .a   (a[i]),
                .b   (b[i]),
                .ci  (link[i]),
                .res (res[i])
            );
            assign sum[i] = res[i].sum;
        end
        assign link[i+1] = res[i].carry;
    end

    assign carry_last = link[WIDTH];
endmodule

// File: rtl/apr_adder.sv
module apr_adder
    import apr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam bit LAST_INVERTED = !is_odd_pos(WIDTH - 1);

    logic chain_carry;

    apr_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .a          (a_i),
        .b          (b_i),
        .cin        (cin_i),
        .sum        (sum_o),
        .carry_last (chain_carry)
    );

    if (LAST_INVERTED) begin : g_fix_polarity
        assign cout_o = ~chain_carry;
    end else begin : g_pass_polarity
        assign cout_o = chain_carry;
    end
endmodule

// File: rtl/apr_adder_chk.sv
module apr_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] ref_total;
    logic           known;

    always_comb begin
        ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
        known     = !$isunknown({a_i, b_i, cin_i});
    end

    always_comb begin
        if (known) begin
            p_total_matches_r1: assert ({cout_o, sum_o} == ref_total)
                else $error("R1 total mismatch");
            if (&a_i && b_i == '0 && cin_i) begin
                p_full_ripple_r2: assert (sum_o == '0 && cout_o)
                    else $error("R2 full ripple");
            end
            if (b_i == '0 && !cin_i) begin
                p_zero_identity_r3: assert (sum_o == a_i && !cout_o)
                    else $error("R3 identity");
            end
            if (b_i == ~a_i) begin
                p_complement_pair_r4: assert (cin_i ? (sum_o == '0 && cout_o)
                                                    : (&sum_o && !cout_o))
                    else $error("R4 complement pair");
            end
            if (a_i[MSB] && b_i[MSB]) begin
                p_msb_generate_r5: assert (cout_o)
                    else $error("R5 generate");
            end
            if (!a_i[MSB] && !b_i[MSB]) begin
                p_msb_kill_r5: assert (!cout_o)
                    else $error("R5 kill");
            end
        end
    end
endmodule

bind apr_adder apr_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .sum_o  (sum_o),
    .cout_o (cout_o)
);

// File: tb/apr_adder_tb.sv
`timescale 1ns/1ps
module apr_adder_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [4:0]  a5, b5, s5;
    logic        c5, co5;
    logic [3:0]  a4, b4, s4;
    logic        c4, co4;

    apr_adder #(.WIDTH(16)) u_dut (
        .a_i(a16), .b_i(b16), .cin_i(c16), .sum_o(s16), .cout_o(co16));
    apr_adder #(.WIDTH(5)) u_dut_w5 (
        .a_i(a5), .b_i(b5), .cin_i(c5), .sum_o(s5), .cout_o(co5));
    apr_adder #(.WIDTH(4)) u_dut_w4 (
        .a_i(a4), .b_i(b4), .cin_i(c4), .sum_o(s4), .cout_o(co4));

    task automatic check(input string tag, input longint got, input longint exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic apply16(input logic [15:0] a, input logic [15:0] b,
                           input logic c, input string tag);
        @(posedge clk);
        a16 = a; b16 = b; c16 = c;
        @(negedge clk);
        check(tag, longint'({co16, s16}), longint'(a) + longint'(b) + longint'(c));
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        a16 = '0; b16 = '0; c16 = 0;
        a5 = '0; b5 = '0; c5 = 0;
        a4 = '0; b4 = '0; c4 = 0;
        @(negedge clk);
        // R3: all-zero inputs give zero outputs
        check("R3 zero inputs", longint'({co16, s16}), 0);

        // R2: carry across the full chain
        apply16(16'hFFFF, 16'h0000, 1'b1, "R2 all-ones plus one");
        check("R2 cout", longint'(co16), 1);
        apply16(16'h0000, 16'hFFFF, 1'b1, "R2 swapped all-ones plus one");
        // R3: identity
        apply16(16'hA5C3, 16'h0000, 1'b0, "R3 identity");
        check("R3 sum equals a", longint'(s16), longint'(16'hA5C3));
        // R4: complement pairs
        apply16(16'h3C96, 16'hC369, 1'b0, "R4 complement cin0");
        check("R4 sum all ones", longint'(s16), longint'(16'hFFFF));
        apply16(16'h3C96, 16'hC369, 1'b1, "R4 complement cin1");
        check("R4 cout set", longint'(co16), 1);
        // R5: MSB generate and kill
        apply16(16'h8000, 16'h8000, 1'b0, "R5 msb generate");
        check("R5 cout generate", longint'(co16), 1);
        apply16(16'h7FFF, 16'h7FFF, 1'b1, "R5 msb kill");
        check("R5 cout kill", longint'(co16), 0);
        apply16(16'hFFFF, 16'hFFFF, 1'b1, "R1 max operands");
        // R1: walking ones and random operands
        for (int k = 0; k < 16; k++) begin
            apply16(16'h1 << k, 16'h1 << k, 1'b1, "R1 walking one");
        end
        for (int k = 0; k < 1500; k++) begin
            apply16(16'($urandom), 16'($urandom), 1'($urandom), "R1 random");
        end

        // R6: exhaustive odd width 5 and even width 4
        for (int va = 0; va < 32; va++) begin
            for (int vb = 0; vb < 32; vb++) begin
                for (int vc = 0; vc < 2; vc++) begin
                    @(posedge clk);
                    a5 = 5'(va); b5 = 5'(vb); c5 = 1'(vc);
                    @(negedge clk);
                    check("R6 width5 exhaustive", longint'({co5, s5}), va + vb + vc);
                end
            end
        end
        for (int va = 0; va < 16; va++) begin
            for (int vb = 0; vb < 16; vb++) begin
                for (int vc = 0; vc < 2; vc++) begin
                    @(posedge clk);
                    a4 = 4'(va); b4 = 4'(vb); c4 = 1'(vc);
                    @(negedge clk);
                    check("R6 width4 exhaustive", longint'({co4, s4}), va + vb + vc);
                end
            end
        end

        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule